// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight edge-sensitive interrupt request lines. It picks the most urgent request that is neither masked nor outranked by work already in service, and signals the processor on a single request line. When the processor pulses the acknowledge input, the block drives an 8-bit vector for that cycle. The vector is formed from a programmable base and the index of the winning line. Priority is fixed: line 0 is the most urgent and line 7 the least.

Software reaches the block through a byte-wide port with one address bit. Address 0 is the command port and address 1 is the data port, and each has a write strobe and a read strobe. A set-up sequence loads three words through the data port: the vector base, a cascade word and a mode word. The mode word selects either explicit end-of-interrupt or automatic end-of-interrupt at acknowledge. After set-up, the data port reads and writes the mask. The command port accepts a specific end-of-interrupt command and two commands that choose which register a command-port read returns.

An acknowledge that arrives when no eligible request exists returns the line-7 vector and changes nothing. This covers the case where the request was masked away after the request line rose. The set-up sequencer is an FSM with four states:
- `ST_RUN`: normal operation. A data write loads the mask.
- `ST_BASE`: the next data write is the vector base.
- `ST_CASC`: the next data write is the cascade word.
- `ST_MODE`: the next data write is the mode word.

The FSM has these transitions:
- A command write of 0x11 moves the FSM from any state to `ST_BASE`.
- A data write moves `ST_BASE` to `ST_CASC`.
- A data write moves `ST_CASC` to `ST_MODE`.
- A data write moves `ST_MODE` to `ST_RUN`.
- A data write in `ST_RUN` stays in `ST_RUN`.

Top module: `irqc_top`

## Requirements
- R1: A command-port write of 0x11, in any state, starts set-up. The start clears the request and in-service registers and selects the request register for command-port reads. The next three data-port writes are taken, in order, as vector base, cascade word and mode word. None of these three writes changes the mask.
- R2: The vector's upper five bits come from bits 7:3 of the base word, whose low three bits are discarded. The lower three bits hold the input index, so with base 0x30, line 3 gives 0x33, and with base 0x38, line 6 gives 0x3E.
- R3: The cascade word is stored unchanged and is driven on `casc_word`.
- R4: Bit 1 of the mode word selects the end-of-interrupt style. A value of 1 (mode word 0x03) selects automatic end-of-interrupt, where an acknowledge sets no in-service bit. A value of 0 (mode word 0x01) selects explicit end-of-interrupt.
- R5: In `ST_RUN`, a data-port write loads the mask and a data-port read returns it. Mask bit n set to 1 blocks line n, and 0xFF blocks every line.
- R6: In `ST_RUN`, a command-port write of 0x60+n (n = 0..7) clears in-service bit n and leaves the other in-service bits unchanged.
- R7: A command-port write of 0x0A makes later command-port reads return the request register. A write of 0x0B makes them return the in-service register. The choice persists until the next such write or the next set-up start.
- R8: An acknowledge while `irq_out` is low returns base+7. It sets no in-service bit and clears no request bit, and this holds even when line 7 is masked.
- R9: `irq_out` is high exactly when some unmasked request has a lower index than every in-service bit, or when some unmasked request exists and nothing is in service.
- R10: An acknowledge while `irq_out` is high returns the vector of the winning line and clears that line's request bit. In explicit mode it also sets that line's in-service bit.
- R11: A rising edge on `irq_in[n]` sets request bit n. A line that stays high does not raise a new request after it has been acknowledged.
- R12: After reset the mask is 0xFF, the request and in-service registers are 0, the base and cascade word are 0, and explicit mode and the request register are selected. `vec_out` is 0 whenever `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when `rd_en` is low |
| irq_in | input | 8 | Interrupt request lines; line 0 is most urgent |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Single-cycle acknowledge pulse |
| vec_out | output | 8 | Vector, valid in the cycle `ack` is high |
| casc_word | output | 8 | Stored cascade word |

## Verification
The bench builds the block with its default of eight lines, so every line index is reachable. The bench then programs two vector bases: one with a clean base, and one whose discarded low bits are set. Both end-of-interrupt styles are run. Nested service is exercised: a more urgent line preempts one in service while a less urgent line waits behind it. The spurious path is reached twice, once by masking away a latched request and once with every line masked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    localparam logic [7:0] CMD_INIT   = 8'h11;
    localparam logic [7:0] CMD_RD_IRR = 8'h0A;
    localparam logic [7:0] CMD_RD_ISR = 8'h0B;
    localparam logic [4:0] EOI_TAG    = 5'b01100;
endpackage

// File: rtl/irqc_init_fsm.sv
module irqc_init_fsm
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output init_st_e   st,
    output logic       init_go,
    output logic       ld_base,
    output logic       ld_casc,
    output logic       ld_mode,
    output logic       ld_mask
);
    init_st_e st_nxt;

    always_comb begin
        st_nxt = st;
        if (cmd_wr && wdata == CMD_INIT) begin
            st_nxt = ST_BASE;
        end else if (data_wr) begin
            unique case (st)
                ST_BASE: st_nxt = ST_CASC;
                ST_CASC: st_nxt = ST_MODE;
                ST_MODE: st_nxt = ST_RUN;
                ST_RUN:  st_nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    always_comb begin
        init_go = cmd_wr && wdata == CMD_INIT;
        ld_base = 1'b0;
        ld_casc = 1'b0;
        ld_mode = 1'b0;
        ld_mask = 1'b0;
        unique case (st)
            ST_BASE: ld_base = data_wr;
            ST_CASC: ld_casc = data_wr;
            ST_MODE: ld_mode = data_wr;
            ST_RUN:  ld_mask = data_wr;
        endcase
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] bits,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN),
    localparam int VW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_sel,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [VW-1:0]   wdata,
    output logic [VW-1:0]   rdata,
    input  logic [N_IN-1:0] irq_in,
    output logic            irq_out,
    input  logic            ack,
    output logic [VW-1:0]   vec_out,
    output logic [VW-1:0]   casc_word
);
    init_st_e        st;
    logic            init_go, ld_base, ld_casc, ld_mode, ld_mask;
    logic            cmd_wr, data_wr, run_mode;
    logic [N_IN-1:0] irr_q, isr_q, mask_q, prev_q;
    logic [VW-1:0]   base_q, casc_q;
    logic            aeoi_q, rsel_isr_q;
    logic            pend_found, isr_found, ack_ok;
    logic [IDXW-1:0] pend_idx, isr_idx;
    logic [N_IN-1:0] win_hot, eoi_hot, rise;
    logic            eoi_cmd;

    assign cmd_wr   = wr_en && !addr_sel;
    assign data_wr  = wr_en && addr_sel;
    assign run_mode = (st == ST_RUN);

    irqc_init_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .wdata(wdata), .st(st), .init_go(init_go), .ld_base(ld_base),
        .ld_casc(ld_casc), .ld_mode(ld_mode), .ld_mask(ld_mask)
    );

    irqc_prio #(.N_IN(N_IN)) u_pend (
        .bits(irr_q & ~mask_q), .found(pend_found), .idx(pend_idx)
    );
    irqc_prio #(.N_IN(N_IN)) u_serv (
        .bits(isr_q), .found(isr_found), .idx(isr_idx)
    );

    assign irq_out = pend_found && (!isr_found || pend_idx < isr_idx);
    assign ack_ok  = ack && irq_out;
    assign rise    = irq_in & ~prev_q;
    assign eoi_cmd = cmd_wr && run_mode && wdata[VW-1:IDXW] == EOI_TAG;

    always_comb begin
        win_hot = '0;
        eoi_hot = '0;
        if (ack_ok)  win_hot[pend_idx] = 1'b1;
        if (eoi_cmd) eoi_hot[wdata[IDXW-1:0]] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q      <= '0;
            isr_q      <= '0;
            mask_q     <= '1;
            prev_q     <= '0;
            base_q     <= '0;
            casc_q     <= '0;
            aeoi_q     <= 1'b0;
            rsel_isr_q <= 1'b0;
        end else begin
            prev_q <= irq_in;
            if (init_go) begin
                irr_q      <= rise;
                isr_q      <= '0;
                rsel_isr_q <= 1'b0;
            end else begin
                irr_q <= (irr_q & ~win_hot) | rise;
                isr_q <= (isr_q & ~eoi_hot) | (aeoi_q ? '0 : win_hot);
                if (cmd_wr && run_mode && wdata == CMD_RD_IRR) rsel_isr_q <= 1'b0;
                if (cmd_wr && run_mode && wdata == CMD_RD_ISR) rsel_isr_q <= 1'b1;
            end
            if (ld_base) base_q <= {wdata[VW-1:IDXW], {IDXW{1'b0}}};
            if (ld_casc) casc_q <= wdata;
            if (ld_mode) aeoi_q <= wdata[1];
            if (ld_mask) mask_q <= wdata;
        end
    end

    always_comb begin
        vec_out = '0;
        if (ack) vec_out = {base_q[VW-1:IDXW], ack_ok ? pend_idx : {IDXW{1'b1}}};
    end

    always_comb begin
        rdata = '0;
        if (rd_en) rdata = addr_sel ? mask_q : (rsel_isr_q ? isr_q : irr_q);
    end

    assign casc_word = casc_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       irq_out,
    input logic [7:0] vec_out,
    input logic [7:0] mask_q,
    input logic [7:0] isr_q,
    input logic [7:0] irr_q,
    input logic [7:0] base_q,
    input logic       aeoi_q,
    input logic       wr_en,
    input logic       addr_sel,
    input logic [7:0] wdata,
    input logic       run_mode
);
    // R8
    spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out && !wr_en) |=> $stable(isr_q));

    // R2
    vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> vec_out[7:3] == base_q[7:3]);

    // R5
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'hFF) |-> !irq_out);

    // R6
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_sel && run_mode && wdata[7:3] == 5'b01100 && !ack)
        |=> !isr_q[$past(wdata[2:0])]);

    // R4
    aeoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi_q && !wr_en) |=> $stable(isr_q));

    // R9
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irr_q & ~mask_q) != 8'h00);

    // R12
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> vec_out == 8'h00);
endmodule

bind irqc_top irqc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .irq_out(irq_out),
    .vec_out(vec_out), .mask_q(mask_q), .isr_q(isr_q), .irr_q(irr_q),
    .base_q(base_q), .aeoi_q(aeoi_q), .wr_en(wr_en), .addr_sel(addr_sel),
    .wdata(wdata), .run_mode(run_mode)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
    localparam int CLK_NS = 8;
    localparam int NV = 61;
    // [31:28] op (0 wr, 1 rd, 2 drive lines, 3 ack, 4 irq_out, 5 cascade)
    // [27:24] addr, [23:16] data, [15:8] expected, [7:0] requirement
    localparam logic [31:0] VEC [NV] = '{
        32'h00110001, // R1 start set-up
        32'h01300002, // R2 base 0x30
        32'h01040003, // R3 cascade word
        32'h01010004, // R4 explicit mode
        32'h1100FF05, // R5 mask untouched by set-up
        32'h01000005, // R5 mask 0
        32'h11000005, // R5 read mask
        32'h2008000B, // R11 edge on line 3
        32'h40000109, // R9
        32'h000A0007, // R7 select request reg
        32'h10000807, // R7
        32'h3000330A, // R10 vector 0x33
        32'h4000000B, // R11 held level, no new request
        32'h1000000A, // R10 request cleared
        32'h000B0007, // R7 select in-service reg
        32'h1000080A, // R10 in-service set
        32'h20280009, // R9 line 5 edge
        32'h40000009, // R9 outranked by line 3
        32'h202A0009, // R9 line 1 edge
        32'h40000109, // R9 preempts
        32'h3000310A, // R10
        32'h10000A0A, // R10
        32'h00610006, // R6 clear line 1
        32'h10000806, // R6
        32'h40000009, // R9
        32'h00630006, // R6 clear line 3
        32'h10000006, // R6
        32'h40000109, // R9
        32'h3000350A, // R10
        32'h1000200A, // R10
        32'h00650006, // R6
        32'h10000006, // R6
        32'h20000008, // R8 lines low
        32'h20040008, // R8 line 2 edge
        32'h40000109, // R9
        32'h01040005, // R5 mask line 2
        32'h40000009, // R5
        32'h30003708, // R8 spurious vector
        32'h10000008, // R8 no in-service
        32'h000A0007, // R7
        32'h10000408, // R8 request kept
        32'h01FF0005, // R5 mask all
        32'h40000005, // R5
        32'h30003708, // R8 line 7 masked
        32'h1100FF05, // R5
        32'h000B0007, // R7
        32'h00110001, // R1 restart
        32'h013F0002, // R2 low bits dropped
        32'h01020003, // R3
        32'h01030004, // R4 auto mode
        32'h1100FF01, // R1 mask kept
        32'h10000001, // R1 request reg selected and cleared
        32'h50000203, // R3
        32'h01000005, // R5
        32'h2000000B, // R11
        32'h2040000B, // R11 line 6 edge
        32'h40000109, // R9
        32'h30003E02, // R2 vector 0x3E
        32'h40000004, // R4 nothing in service
        32'h000B0007, // R7
        32'h10000004  // R4 in-service stays 0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] rdata, vec_out, casc_word;
    logic       irq_out;
    int         n_chk = 0, n_fail = 0;

    always #(CLK_NS / 2) clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
        .irq_out(irq_out), .ack(ack), .vec_out(vec_out), .casc_word(casc_word)
    );

    task automatic chk(input int tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %02h expected %02h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        rd_en = 1'b1; addr_sel = 1'b1;
        #1;
        chk(12, rdata, 8'hFF);
        chk(12, {7'd0, irq_out}, 8'h00);
        chk(12, vec_out, 8'h00);
        chk(12, casc_word, 8'h00);
        addr_sel = 1'b0;
        #1;
        chk(12, rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0;
            addr_sel = v[24];
            case (v[31:28])
                4'd0: begin wdata = v[23:16]; wr_en = 1'b1; end
                4'd1: rd_en = 1'b1;
                4'd2: irq_in = v[23:16];
                4'd3: ack = 1'b1;
                default: ;
            endcase
            #1;
            case (v[31:28])
                4'd1: chk(int'(v[7:0]), rdata, v[15:8]);
                4'd3: chk(int'(v[7:0]), vec_out, v[15:8]);
                4'd4: chk(int'(v[7:0]), {7'd0, irq_out}, v[15:8]);
                4'd5: chk(int'(v[7:0]), casc_word, v[15:8]);
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0;

        // R12 reset in the middle of operation restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        irq_in = 8'h00;
        @(negedge clk);
        rd_en = 1'b1; addr_sel = 1'b1;
        #1;
        chk(12, rdata, 8'hFF);
        chk(12, casc_word, 8'h00);
        chk(12, {7'd0, irq_out}, 8'h00);
        // R12 vector idle while ack low
        chk(12, vec_out, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule